// File: doc/BRIEF.md
# Byte-Lane Masked Single-Port RAM

This block is a single-port synchronous memory. Its word width does not have to be a whole multiple of its write lane width. The word is cut into lanes of a fixed number of bits, starting from bit 0. When the word width leaves a remainder, the topmost lane is short and holds only those leftover bits. The mask has one bit per lane, and the count of lanes is rounded up, so every data bit sits under some mask bit. With the default 25-bit word and 8-bit lanes there are four mask bits, and the fourth one governs bit 24 on its own.

Each clock edge performs one access, chosen by two active-low controls. A write changes only the lanes whose mask bit is set. A read returns the addressed word through an output register one edge later. That register keeps its value through write and idle cycles. Reset is asserted asynchronously and released through a two-stage synchronizer. The array accepts no access until that release has propagated. Reset clears the read register but not the stored contents.

Top module: `lane_sram`

## Requirements
- R1: The mask has ceil(DATA_W / LANE_W) bits, which is 4 bits for a 25-bit word with 8-bit lanes. Mask bit 3 alone controls data bit 24.
- R2: Mask bit i controls data bits i*LANE_W up to min((i+1)*LANE_W, DATA_W)-1, and no other bits.
- R3: A write takes place on a rising clock edge when cs_n=0 and we_n=0. It updates only the lanes whose mask bit is 1.
- R4: The short top lane can be written and read back like any full lane.
- R5: A read takes place when cs_n=0 and we_n=1. After that rising edge, rdata holds the word stored at addr before that edge.
- R6: During a write cycle, rdata keeps its previous value.
- R7: When cs_n=1, the stored contents do not change and rdata keeps its value, whatever we_n, addr, wdata and wmask carry.
- R8: While rst_n=0, rdata is 0 and no write takes effect. After rst_n rises, accesses in the first two clock edges are ignored. Stored contents survive reset.
- R9: A write with an all-zero mask leaves the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable (1 selects a read) |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| wmask | input | NUM_LANES | Per-lane write enable, bit i selects lane i |
| rdata | output | DATA_W | Registered read data |

## Verification
A write and the read register's hold meet in the same cycle. A write must leave rdata alone while it changes the very word that the previous read returned. The bench reads an address, writes new data to that same address on the next edge, and checks that rdata still shows the old word. A following read must then return the new word, merged according to the mask. Reset release meets an access in the same way: a write issued on the first edge after rst_n rises must be dropped, and this is judged by reading that address back later.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lane_op_e;

  // lanes needed to cover every bit of a word (rounded up)
  function automatic int lane_count(input int word_w, input int lane_w);
    return (word_w + lane_w - 1) / lane_w;
  endfunction

  // first data bit of lane idx
  function automatic int lane_base(input int idx, input int lane_w);
    return idx * lane_w;
  endfunction

  // bit count of lane idx; the last lane may be short
  function automatic int lane_bits(input int idx, input int lane_w, input int word_w);
    return ((idx + 1) * lane_w > word_w) ? (word_w - idx * lane_w) : lane_w;
  endfunction

endpackage

// File: rtl/lane_sram_rst_sync.sv
module lane_sram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ok = sync_q[STAGES-1];

endmodule

// File: rtl/lane_sram_ctrl.sv
module lane_sram_ctrl
  import lane_sram_pkg::*;
(
  input  logic     cs_n,
  input  logic     we_n,
  input  logic     rst_ok,
  output lane_op_e op
);

  always_comb begin
    if (!rst_ok || cs_n) begin
      op = OP_IDLE;
    end else if (!we_n) begin
      op = OP_WRITE;
    end else begin
      op = OP_READ;
    end
  end

endmodule

// File: rtl/lane_sram_store.sv
module lane_sram_store
  import lane_sram_pkg::*;
#(
  parameter int  DATA_W    = 25,
  parameter int  LANE_W    = 8,
  parameter int  DEPTH     = 16,
  localparam int NUM_LANES = lane_count(DATA_W, LANE_W),
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_LANES-1:0] lane_we,
  output logic [DATA_W-1:0]    rd_word
);

  // one independent array per lane; the last one is only as wide as the remainder
  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
    localparam int LO = lane_base(gi, LANE_W);
    localparam int LB = lane_bits(gi, LANE_W, DATA_W);

    logic [LB-1:0] cell_q [DEPTH];
    logic [LB-1:0] cell_d;
    logic          cell_we;

    always_comb begin
      cell_we = wr_en & lane_we[gi];
      cell_d  = wdata[LO +: LB];
    end

    always_ff @(posedge clk) begin
      if (cell_we) begin
        cell_q[addr] <= cell_d;
      end
    end

    assign rd_word[LO +: LB] = cell_q[addr];
  end

endmodule

// File: rtl/lane_sram_rdreg.sv
module lane_sram_rdreg #(
  parameter int DATA_W = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] dout_d;

  always_comb begin
    dout_d = load ? din : dout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else begin
      dout <= dout_d;
    end
  end

endmodule

// File: rtl/lane_sram.sv
module lane_sram
  import lane_sram_pkg::*;
#(
  parameter int  DATA_W    = 25,
  parameter int  LANE_W    = 8,
  parameter int  DEPTH     = 16,
  localparam int NUM_LANES = lane_count(DATA_W, LANE_W),
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 we_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_LANES-1:0] wmask,
  output logic [DATA_W-1:0]    rdata
);

  logic              rst_ok;
  lane_op_e          op;
  logic              wr_en;
  logic              rd_en;
  logic [DATA_W-1:0] rd_word;

  lane_sram_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_ok(rst_ok)
  );

  lane_sram_ctrl u_ctrl (
    .cs_n  (cs_n),
    .we_n  (we_n),
    .rst_ok(rst_ok),
    .op    (op)
  );

  always_comb begin
    wr_en = (op == OP_WRITE);
    rd_en = (op == OP_READ);
  end

  lane_sram_store #(
    .DATA_W(DATA_W),
    .LANE_W(LANE_W),
    .DEPTH (DEPTH)
  ) u_store (
    .clk    (clk),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .lane_we(wmask),
    .rd_word(rd_word)
  );

  lane_sram_rdreg #(
    .DATA_W(DATA_W)
  ) u_rdreg (
    .clk  (clk),
    .rst_n(rst_n),
    .load (rd_en),
    .din  (rd_word),
    .dout (rdata)
  );

endmodule

// File: rtl/lane_sram_chk.sv
module lane_sram_chk
  import lane_sram_pkg::*;
#(
  parameter int  DATA_W    = 25,
  parameter int  LANE_W    = 8,
  parameter int  DEPTH     = 16,
  localparam int NUM_LANES = lane_count(DATA_W, LANE_W),
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 we_n,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wdata,
  input logic [NUM_LANES-1:0] wmask,
  input logic [DATA_W-1:0]    rdata
);

  // edges seen since reset release, saturating; accesses count once it reaches 3
  logic [1:0] up_q;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0;
    end else if (up_q != 2'd3) begin
      up_q <= up_q + 2'd1;
    end
  end

  assign armed = (up_q == 2'd3);

  AST_RESET_CLEARS_RDATA: assert property (@(posedge clk)
    !rst_n |-> (rdata == '0)); // R8

  AST_WRITE_HOLDS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> $stable(rdata)); // R6

  AST_DESELECT_HOLDS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(rdata)); // R7

  AST_FULL_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cs_n && !we_n && (&wmask)) ##1 (!cs_n && we_n && (addr == $past(addr)))
    |=> (rdata == $past(wdata, 2))); // R5

endmodule

bind lane_sram lane_sram_chk #(
  .DATA_W(DATA_W),
  .LANE_W(LANE_W),
  .DEPTH (DEPTH)
) u_lane_sram_chk (.*);

// File: tb/test_lane_sram.sv
`timescale 1ns/1ps
module test_lane_sram;

  localparam int DW    = 25;
  localparam int LW    = 8;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int NL    = (DW + LW - 1) / LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n;
  logic          we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [NL-1:0] wmask;
  logic [DW-1:0] rdata;

  logic [DW-1:0] model [DEPTH];
  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lane_sram #(
    .DATA_W(DW),
    .LANE_W(LW),
    .DEPTH (DEPTH)
  ) i_lane_sram (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (cs_n),
    .we_n (we_n),
    .addr (addr),
    .wdata(wdata),
    .wmask(wmask),
    .rdata(rdata)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bit b is replaced when its lane's mask bit (lane = b / LW) is set
  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [NL-1:0] m);
    logic [DW-1:0] r;
    for (int b = 0; b < DW; b++) r[b] = m[b / LW] ? new_w[b] : old_w[b];
    return r;
  endfunction

  function automatic logic [DW-1:0] pattern(input int a, input int k);
    logic [31:0] h;
    h = 32'h9E37_79B1 * (a * 37 + k * 101 + 1);
    return h[DW-1:0] ^ h[31:32-DW];
  endfunction

  // one access: drive at negedge, sample 1 ns after the capturing edge
  task automatic cyc(input logic c, input logic w, input int a,
                     input logic [DW-1:0] d, input logic [NL-1:0] m);
    @(negedge clk);
    cs_n  = c;
    we_n  = w;
    addr  = a[AW-1:0];
    wdata = d;
    wmask = m;
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d, input logic [NL-1:0] m);
    cyc(1'b0, 1'b0, a, d, m);
    model[a] = merge(model[a], d, m);
  endtask

  task automatic do_read(input int a, output logic [DW-1:0] v);
    cyc(1'b0, 1'b1, a, '0, '0);
    v = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 0, '0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    logic [DW-1:0] held;
    rst_n = 1'b0;
    cs_n  = 1'b1;
    we_n  = 1'b1;
    addr  = '0;
    wdata = '0;
    wmask = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset value", rdata, '0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R3 R5: fill every address with full-mask writes, read back
    for (int a = 0; a < DEPTH; a++) do_write(a, pattern(a, 0), '1);
    for (int a = 0; a < DEPTH; a++) begin
      do_read(a, v);
      check("R5 full readback", v, model[a]);
    end

    // R2 R3 R9 R4: every mask value on every address
    for (int a = 0; a < DEPTH; a++) begin
      for (int m = 0; m < (1 << NL); m++) begin
        do_write(a, pattern(a, m + 1), m[NL-1:0]);
        do_read(a, v);
        if (m == 0) check("R9 zero mask", v, model[a]);
        else if (m[NL-1]) check("R4 top lane", v, model[a]);
        else check("R2 R3 lane mapping", v, model[a]);
      end
    end

    // R1: only mask bit 3 -> only bit 24 changes
    do_write(3, '0, '1);
    do_write(3, '1, 4'b1000);
    do_read(3, v);
    check("R1 mask bit 3 covers bit 24", v, 25'h100_0000);
    do_write(3, '1, 4'b0111);
    do_write(3, '0, 4'b1000);
    do_read(3, v);
    check("R1 clear bit 24 alone", v, 25'h0FF_FFFF);

    // R6: read, then write the same word; rdata holds, then new value
    do_read(7, held);
    do_write(7, ~model[7], '1);
    check("R6 rdata hold on write", rdata, held);
    do_read(7, v);
    check("R6 new data after write", v, model[7]);

    // R7: deselected write attempt and deselected read
    do_read(8, held);
    cyc(1'b1, 1'b0, 8, ~model[8], '1);
    check("R7 rdata hold deselected write", rdata, held);
    cyc(1'b1, 1'b1, 9, '0, '0);
    check("R7 rdata hold deselected read", rdata, held);
    do_read(8, v);
    check("R7 contents unchanged", v, model[8]);

    // R5: back-to-back reads of different words
    do_read(10, v);
    check("R5 back-to-back A", v, model[10]);
    do_read(11, v);
    check("R5 back-to-back B", v, model[11]);

    // R8: mid-run reset; writes during and right after reset are dropped
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 async clear", rdata, '0);
    cyc(1'b0, 1'b0, 5, ~model[5], '1);
    @(negedge clk);
    rst_n = 1'b1;
    cs_n  = 1'b0;
    we_n  = 1'b0;
    addr  = 4'd6;
    wdata = ~model[6];
    wmask = '1;
    @(posedge clk);
    #1;
    check("R8 rdata during sync", rdata, '0);
    idle(3);
    do_read(5, v);
    check("R8 write in reset ignored", v, model[5]);
    do_read(6, v);
    check("R8 write at release ignored", v, model[6]);

    finish_run();
  end

endmodule